// File: doc/BRIEF.md
# Synchronous Dual-Port Burst RAM

This block is a true dual-port memory of 9-bit words with two fully independent synchronous ports, called left and right. The ports may read or write any location on the same clock edge, including the same location. The depth is `2**ADDR_W` words. A chip build sets `ADDR_W` to 13 for 8K words or to 14 for 16K words. The default is kept small so that the block elaborates cheaply.

Each port owns an address register that is also a burst counter. On every rising edge of its clock the register performs one of four operations, chosen by priority from three active-low controls:

- `CTR_CLEAR`: the address becomes zero.
- `CTR_LOAD`: the address takes the external address.
- `CTR_STEP`: the address increments.
- `CTR_HOLD`: the address keeps its value.

The value the register takes on an edge is the address accessed on that edge. This lets a host issue one address and then stream words by holding the step control low.

Each port has a read-output stage that works in one of two modes, selected by a per-port pin:

- `OUT_FLOW`: the word read on an edge is presented straight after that edge.
- `OUT_PIPE`: the word passes through one more register and appears one edge later.

The block has no tri-state pins. An undriven data bus is shown as a low drive flag together with an all-zero data bus. Storage uses two single-writer banks whose XOR gives the stored word. Each bank is written only by its own port's clock.

Top module: `twin_burst_ram`

## Requirements
- R1: On a rising edge where the port is selected (`*_ce_lo_n`=0 and `*_ce_hi`=1) and `*_rw_n`=0, the word on `*_din` is stored at the address taken by that port's address register on that edge.
- R2: When `*_ce_lo_n`=1 or `*_ce_hi`=0 on an edge, that port neither writes memory nor starts a read. Its drive flag stays 0 for that access.
- R3: On each rising edge the address register takes its next value by priority. `*_clr_n`=0 gives zero. Otherwise `*_ads_n`=0 loads `*_addr`. Otherwise `*_step_n`=0 increments the address. Otherwise the address holds. This happens whether or not the port is selected.
- R4: Incrementing from address `2**ADDR_W-1` gives address 0.
- R5: With `*_pipe`=0, a read started on an edge (selected, `*_rw_n`=1) shows its word on `*_dout` after that edge and before the next one.
- R6: With `*_pipe`=1, the word of a read started on an edge shows on `*_dout` after the following edge. Nothing is shown after the first edge.
- R7: `*_drv` is 1 only while a read result is due for the current mode and `*_oe_n`=0. `*_oe_n` acts without a clock. While `*_drv`=0, `*_dout` is all zeros.
- R8: A word written on one port can be read back on either port, and both ports can read the same location on the same edge.
- R9: If both ports write the same address on a common edge, the right port's word is stored.
- R10: A read on one port of an address that the other port writes on the same edge returns the word stored before that edge.
- R11: After reset both address registers are 0 and both drive flags are 0.
- R12: Burst stepping works in pipelined mode, delivering consecutive words one per cycle after a one-cycle lag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| clk_r | input | 1 | Right port clock |
| rst_n | input | 1 | Asynchronous active-low reset of the registers |
| l_ce_lo_n | input | 1 | Left select, must be low |
| l_ce_hi | input | 1 | Left select, must be high |
| l_rw_n | input | 1 | Left read (1) or write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_pipe | input | 1 | Left output mode, 1 = pipelined |
| l_clr_n | input | 1 | Left counter clear, active low |
| l_ads_n | input | 1 | Left address load strobe, active low |
| l_step_n | input | 1 | Left counter step enable, active low |
| l_addr | input | ADDR_W | Left external address |
| l_din | input | DATA_W | Left write data |
| l_dout | output | DATA_W | Left read data, zero when not driven |
| l_drv | output | 1 | Left data bus driven |
| r_ce_lo_n | input | 1 | Right select, must be low |
| r_ce_hi | input | 1 | Right select, must be high |
| r_rw_n | input | 1 | Right read (1) or write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_pipe | input | 1 | Right output mode, 1 = pipelined |
| r_clr_n | input | 1 | Right counter clear, active low |
| r_ads_n | input | 1 | Right address load strobe, active low |
| r_step_n | input | 1 | Right counter step enable, active low |
| r_addr | input | ADDR_W | Right external address |
| r_din | input | DATA_W | Right write data |
| r_dout | output | DATA_W | Right read data, zero when not driven |
| r_drv | output | 1 | Right data bus driven |

## Verification
Both port clocks come from one bench clock. Inputs change on its falling edge, so each rising edge samples stable controls.

- A flow-through read is compared at the falling edge that follows its rising edge, because it passes one register.
- A pipelined read is compared one full cycle later, because it passes two registers. The cycle in between is checked for an undriven bus.
- A pipelined burst is checked one word per cycle from the second edge on.
- Output enable is combinational. Its effect is checked a moment after toggling it inside the same cycle.
- Counter operations and same-edge collisions are checked by reading the affected addresses back through the normal ports.

// File: rtl/twb_pkg.sv
package twb_pkg;

    // Operation performed by a port's address register on a clock edge.
    typedef enum logic [1:0] {
        CTR_CLEAR = 2'd0,
        CTR_LOAD  = 2'd1,
        CTR_STEP  = 2'd2,
        CTR_HOLD  = 2'd3
    } ctr_op_t;

    // Read output latency mode of a port.
    typedef enum logic {
        OUT_FLOW = 1'b0,
        OUT_PIPE = 1'b1
    } out_mode_t;

endpackage

// File: rtl/twb_addr_ctr.sv
module twb_addr_ctr
    import twb_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_n,
    input  logic          ads_n,
    input  logic          step_n,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] next_addr
);

    logic [AW-1:0] cur_q;
    ctr_op_t       op;

    // Priority selection of the operation.
    always_comb begin
        if (!clr_n)       op = CTR_CLEAR;
        else if (!ads_n)  op = CTR_LOAD;
        else if (!step_n) op = CTR_STEP;
        else              op = CTR_HOLD;
    end

    // Next address; also the address accessed on this edge.
    always_comb begin
        unique case (op)
            CTR_CLEAR: next_addr = '0;
            CTR_LOAD:  next_addr = ext_addr;
            CTR_STEP:  next_addr = cur_q + 1'b1;
            CTR_HOLD:  next_addr = cur_q;
            default:   next_addr = cur_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= next_addr;
    end

    p_ctr_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> cur_q == '0);

    p_ctr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !ads_n) |=> cur_q == $past(ext_addr));

    p_ctr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ads_n && !step_n) |=> cur_q == AW'($past(cur_q) + 1'b1));

    p_ctr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && ads_n && step_n) |=> $stable(cur_q));

endmodule

// File: rtl/twb_read_stage.sv
module twb_read_stage
    import twb_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic          fire,
    input  logic          oe_n,
    input  logic [DW-1:0] word_in,
    output logic [DW-1:0] dout,
    output logic          drv
);

    logic [DW-1:0] w1_q, w2_q;
    logic          v1_q, v2_q;
    logic [DW-1:0] sel_w;
    logic          sel_v;
    out_mode_t     mode;

    assign mode = out_mode_t'(pipe_mode);

    // Register process: first stage captures the read, second adds a cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w1_q <= '0;
            v1_q <= 1'b0;
            w2_q <= '0;
            v2_q <= 1'b0;
        end else begin
            v1_q <= fire;
            if (fire) w1_q <= word_in;
            v2_q <= v1_q;
            w2_q <= w1_q;
        end
    end

    // Output process: pick the stage for the mode, gate with output enable.
    always_comb begin
        unique case (mode)
            OUT_FLOW: begin sel_w = w1_q; sel_v = v1_q; end
            OUT_PIPE: begin sel_w = w2_q; sel_v = v2_q; end
        endcase
        drv  = sel_v && !oe_n;
        dout = drv ? sel_w : '0;
    end

    p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (!drv && dout == '0));

    p_flow_lat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && drv) |-> $past(fire));

    p_pipe_lag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && $past(pipe_mode) && drv) |-> $past(fire, 2));

endmodule

// File: rtl/twb_port.sv
module twb_port #(
    parameter int AW = 10,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_lo_n,
    input  logic          ce_hi,
    input  logic          rw_n,
    input  logic          oe_n,
    input  logic          pipe_mode,
    input  logic          clr_n,
    input  logic          ads_n,
    input  logic          step_n,
    input  logic [AW-1:0] ext_addr,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] peer_word,
    input  logic          yield,
    input  logic [AW-1:0] look_addr,
    output logic [DW-1:0] look_word,
    output logic [AW-1:0] acc_addr,
    output logic          wr_en,
    output logic [DW-1:0] dout,
    output logic          drv
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] bank [DEPTH];
    logic          sel;
    logic          fire;
    logic [DW-1:0] word_now;

    assign sel   = !ce_lo_n && ce_hi;
    assign wr_en = sel && !rw_n;
    assign fire  = sel && rw_n;

    twb_addr_ctr #(.AW(AW)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n     (clr_n),
        .ads_n     (ads_n),
        .step_n    (step_n),
        .ext_addr  (ext_addr),
        .next_addr (acc_addr)
    );

    // Own bank, written only from this port's clock; the stored word is
    // the XOR of both banks at one address.
    always_ff @(posedge clk) begin
        if (wr_en && !yield) bank[acc_addr] <= din ^ peer_word;
    end

    assign look_word = bank[look_addr];
    assign word_now  = bank[acc_addr] ^ peer_word;

    twb_read_stage #(.DW(DW)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_mode (pipe_mode),
        .fire      (fire),
        .oe_n      (oe_n),
        .word_in   (word_now),
        .dout      (dout),
        .drv       (drv)
    );

endmodule

// File: rtl/twin_burst_ram.sv
module twin_burst_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 9
) (
    input  logic              clk_l,
    input  logic              clk_r,
    input  logic              rst_n,
    input  logic              l_ce_lo_n,
    input  logic              l_ce_hi,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic              l_pipe,
    input  logic              l_clr_n,
    input  logic              l_ads_n,
    input  logic              l_step_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_din,
    output logic [DATA_W-1:0] l_dout,
    output logic              l_drv,
    input  logic              r_ce_lo_n,
    input  logic              r_ce_hi,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic              r_pipe,
    input  logic              r_clr_n,
    input  logic              r_ads_n,
    input  logic              r_step_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_din,
    output logic [DATA_W-1:0] r_dout,
    output logic              r_drv
);

    logic [ADDR_W-1:0] acc_l, acc_r;
    logic [DATA_W-1:0] look_l, look_r;
    logic              wr_l, wr_r;
    logic              yield_l;

    // Same-address write on a common edge: the left port stands down so the
    // right port's word is what both banks decode to (R9).
    assign yield_l = wr_l && wr_r && (acc_l == acc_r);

    twb_port #(.AW(ADDR_W), .DW(DATA_W)) u_left (
        .clk       (clk_l),
        .rst_n     (rst_n),
        .ce_lo_n   (l_ce_lo_n),
        .ce_hi     (l_ce_hi),
        .rw_n      (l_rw_n),
        .oe_n      (l_oe_n),
        .pipe_mode (l_pipe),
        .clr_n     (l_clr_n),
        .ads_n     (l_ads_n),
        .step_n    (l_step_n),
        .ext_addr  (l_addr),
        .din       (l_din),
        .peer_word (look_r),
        .yield     (yield_l),
        .look_addr (acc_r),
        .look_word (look_l),
        .acc_addr  (acc_l),
        .wr_en     (wr_l),
        .dout      (l_dout),
        .drv       (l_drv)
    );

    twb_port #(.AW(ADDR_W), .DW(DATA_W)) u_right (
        .clk       (clk_r),
        .rst_n     (rst_n),
        .ce_lo_n   (r_ce_lo_n),
        .ce_hi     (r_ce_hi),
        .rw_n      (r_rw_n),
        .oe_n      (r_oe_n),
        .pipe_mode (r_pipe),
        .clr_n     (r_clr_n),
        .ads_n     (r_ads_n),
        .step_n    (r_step_n),
        .ext_addr  (r_addr),
        .din       (r_din),
        .peer_word (look_l),
        .yield     (1'b0),
        .look_addr (acc_l),
        .look_word (look_r),
        .acc_addr  (acc_r),
        .wr_en     (wr_r),
        .dout      (r_dout),
        .drv       (r_drv)
    );

endmodule

// File: tb/sim_twin_burst_ram.sv
module sim_twin_burst_ram;

    localparam int AW   = 10;
    localparam int DW   = 9;
    localparam logic [AW-1:0] MAXA = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          l_ce_lo_n, l_ce_hi, l_rw_n, l_oe_n, l_pipe, l_clr_n, l_ads_n, l_step_n;
    logic [AW-1:0] l_addr;
    logic [DW-1:0] l_din, l_dout;
    logic          l_drv;
    logic          r_ce_lo_n, r_ce_hi, r_rw_n, r_oe_n, r_pipe, r_clr_n, r_ads_n, r_step_n;
    logic [AW-1:0] r_addr;
    logic [DW-1:0] r_din, r_dout;
    logic          r_drv;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    twin_burst_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk_l(clk), .clk_r(clk), .rst_n(rst_n),
        .l_ce_lo_n(l_ce_lo_n), .l_ce_hi(l_ce_hi), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n),
        .l_pipe(l_pipe), .l_clr_n(l_clr_n), .l_ads_n(l_ads_n), .l_step_n(l_step_n),
        .l_addr(l_addr), .l_din(l_din), .l_dout(l_dout), .l_drv(l_drv),
        .r_ce_lo_n(r_ce_lo_n), .r_ce_hi(r_ce_hi), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n),
        .r_pipe(r_pipe), .r_clr_n(r_clr_n), .r_ads_n(r_ads_n), .r_step_n(r_step_n),
        .r_addr(r_addr), .r_din(r_din), .r_dout(r_dout), .r_drv(r_drv)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic set_l(input logic cl, input logic ch, input logic rw, input logic cr,
                         input logic ad, input logic st, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
        l_ce_lo_n = cl; l_ce_hi = ch; l_rw_n = rw; l_clr_n = cr;
        l_ads_n = ad; l_step_n = st; l_addr = a; l_din = d;
    endtask

    task automatic set_r(input logic cl, input logic ch, input logic rw, input logic cr,
                         input logic ad, input logic st, input logic [AW-1:0] a,
                         input logic [DW-1:0] d);
        r_ce_lo_n = cl; r_ce_hi = ch; r_rw_n = rw; r_clr_n = cr;
        r_ads_n = ad; r_step_n = st; r_addr = a; r_din = d;
    endtask

    task automatic idle_l(); set_l(1, 0, 1, 1, 1, 1, '0, '0); endtask
    task automatic idle_r(); set_r(1, 0, 1, 1, 1, 1, '0, '0); endtask

    task automatic l_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        set_l(0, 1, 0, 1, 0, 1, a, d); tick(); idle_l();
    endtask

    task automatic r_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        set_r(0, 1, 0, 1, 0, 1, a, d); tick(); idle_r();
    endtask

    // Left port is flow-through: result due one edge after the read.
    task automatic l_rd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        set_l(0, 1, 1, 1, 0, 1, a, '0); tick(); idle_l();
        chk(req, l_dout, exp);
    endtask

    // Right port is pipelined: result due two edges after the read.
    task automatic r_rd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        set_r(0, 1, 1, 1, 0, 1, a, '0); tick(); idle_r(); tick();
        chk(req, r_dout, exp);
    endtask

    task automatic t_reset();
        chk("R11 left drive after reset", {8'd0, l_drv}, 9'd0);
        chk("R11 right drive after reset", {8'd0, r_drv}, 9'd0);
        chk("R11 left dout after reset", l_dout, 9'd0);
        // Hold operation writes at the counter's reset value, address 0.
        set_l(0, 1, 0, 1, 1, 1, 10'd0, 9'h0C3); tick(); idle_l();
        l_rd("R11 counter starts at 0", 10'd0, 9'h0C3);
    endtask

    task automatic t_flow();
        l_wr(10'd5, 9'h1A5);
        l_rd("R1 R5 flow read", 10'd5, 9'h1A5);
        chk("R5 flow drive on", {8'd0, l_drv}, 9'd1);
        tick();
        chk("R5 flow result lasts one cycle", {8'd0, l_drv}, 9'd0);
        l_oe_n = 1'b1;
        set_l(0, 1, 1, 1, 0, 1, 10'd5, '0); tick(); idle_l();
        chk("R7 oe high no drive", {8'd0, l_drv}, 9'd0);
        chk("R7 oe high dout zero", l_dout, 9'd0);
        l_oe_n = 1'b0; #1;
        chk("R7 oe acts without clock", l_dout, 9'h1A5);
        tick();
    endtask

    task automatic t_pipe();
        set_r(0, 1, 1, 1, 0, 1, 10'd5, '0);
        set_l(0, 1, 1, 1, 0, 1, 10'd5, '0);
        tick(); idle_r(); idle_l();
        chk("R6 pipe nothing after first edge", {8'd0, r_drv}, 9'd0);
        chk("R8 left reads same word same edge", l_dout, 9'h1A5);
        tick();
        chk("R6 R8 pipe read on right", r_dout, 9'h1A5);
        chk("R6 pipe drive on", {8'd0, r_drv}, 9'd1);
    endtask

    task automatic t_priority();
        set_l(0, 1, 0, 0, 0, 0, 10'd77, 9'h111); tick();   // clear beats load
        set_l(0, 1, 0, 1, 0, 0, 10'd50, 9'h122); tick();   // load beats step
        set_l(0, 1, 0, 1, 1, 1, 10'd9, 9'h133);  tick();   // hold stays at 50
        set_l(0, 1, 0, 1, 1, 0, 10'd9, 9'h144);  tick();   // step to 51
        idle_l();
        l_rd("R3 clear wins", 10'd0, 9'h111);
        l_rd("R3 load then hold", 10'd50, 9'h133);
        l_rd("R3 step", 10'd51, 9'h144);
    endtask

    task automatic t_burst();
        set_l(0, 1, 0, 1, 0, 1, 10'd100, 9'h0A0); tick();
        for (int i = 1; i < 4; i++) begin
            set_l(0, 1, 0, 1, 1, 0, '0, 9'(9'h0A0 + i)); tick();
        end
        idle_l();
        set_r(0, 1, 1, 1, 0, 1, 10'd100, '0); tick();
        set_r(0, 1, 1, 1, 1, 0, '0, '0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R12 pipelined burst word", r_dout, 9'(9'h0A0 + i));
        end
        idle_r(); tick();
        chk("R12 pipelined burst last word", r_dout, 9'h0A3);
        tick();
        chk("R12 burst ends", {8'd0, r_drv}, 9'd0);
    endtask

    task automatic t_wrap();
        l_wr(MAXA, 9'h0F0);
        set_l(0, 1, 0, 1, 1, 0, '0, 9'h00F); tick(); idle_l();
        l_rd("R4 step from top lands on 0", 10'd0, 9'h00F);
        l_rd("R4 top word kept", MAXA, 9'h0F0);
    endtask

    task automatic t_select();
        l_wr(10'd200, 9'h055);
        set_l(1, 1, 0, 1, 0, 1, 10'd200, 9'h1EE); tick();
        set_l(0, 0, 0, 1, 0, 1, 10'd200, 9'h1EF); tick();
        idle_l();
        l_rd("R2 deselected writes ignored", 10'd200, 9'h055);
        set_l(1, 1, 1, 1, 0, 1, 10'd200, '0); tick(); idle_l();
        chk("R2 deselected read no drive", {8'd0, l_drv}, 9'd0);
    endtask

    task automatic t_collide();
        set_l(0, 1, 0, 1, 0, 1, 10'd300, 9'h011);
        set_r(0, 1, 0, 1, 0, 1, 10'd300, 9'h122);
        tick(); idle_l(); idle_r();
        l_rd("R9 right wins same address", 10'd300, 9'h122);
        set_l(0, 1, 0, 1, 0, 1, 10'd301, 9'h0A1);
        set_r(0, 1, 0, 1, 0, 1, 10'd302, 9'h0B2);
        tick(); idle_l(); idle_r();
        l_rd("R8 separate writes left word", 10'd301, 9'h0A1);
        r_rd("R8 separate writes right word", 10'd302, 9'h0B2);
        l_wr(10'd310, 9'h0AA);
        set_r(0, 1, 0, 1, 0, 1, 10'd310, 9'h155);
        set_l(0, 1, 1, 1, 0, 1, 10'd310, '0);
        tick(); idle_l(); idle_r();
        chk("R10 left read sees old word", l_dout, 9'h0AA);
        l_rd("R10 new word after", 10'd310, 9'h155);
        r_wr(10'd311, 9'h066);
        set_l(0, 1, 0, 1, 0, 1, 10'd311, 9'h199);
        set_r(0, 1, 1, 1, 0, 1, 10'd311, '0);
        tick(); idle_l(); idle_r(); tick();
        chk("R10 right read sees old word", r_dout, 9'h066);
        r_rd("R10 right new word after", 10'd311, 9'h199);
    endtask

    initial begin
        idle_l(); idle_r();
        l_oe_n = 1'b0; r_oe_n = 1'b0;
        l_pipe = 1'b0; r_pipe = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_flow();
        t_pipe();
        t_priority();
        t_burst();
        t_wrap();
        t_select();
        t_collide();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            end
            wait (done);
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule